// File: doc/BRIEF.md
# Peripheral I/O Window Decoder

This block sits between a 68000-style bus master and a group of memory-mapped peripherals that share one 16-bit I/O window. Each accepted access is classified by its word address into one of seven regions. The regions are memory configuration, video, DMA, a programmable sound generator, a multi-function timer block, and two serial ACIAs. The block then issues the matching chip-select, the register index (the address shifted right by one) and the write data. One cycle later it returns an acknowledge together with the read data.

Video and DMA registers move full 16-bit words. All the 8-bit peripherals talk on the upper byte lane of the bus:
- A written byte is taken from bus bits 15:8 and handed to the peripheral on its low byte.
- A read byte comes back on bus bits 15:8, with the low byte filled with ones.

Decoding is partial:
- The sound generator answers everywhere in a 128-word window.
- Address bit 1 chooses between its latch phase and its data phase.
- Address bit 2 chooses between the keyboard ACIA and the MIDI ACIA.

A sound access is not a single-cycle select. After a wait of `WAIT_CYCLES` clock cycles, the block drives the generator's three bus-control lines for exactly one cycle, returns them to all-zero, and then acknowledges. With the acknowledge it reports the added delay in half-cycles.

Top module: `io_window_decoder`

## Requirements
- R1: While reset is asserted and right after its release, bus_ack, bus_vpa, bus_unmapped, per_rd and per_wr are 0, per_cs is all zeros, and psg_bdir, psg_bc2 and psg_bc1 are all 0.
- R2: Decoding ignores address bit 0, and per_index equals bus_addr[15:1]. Word address 0x8000 selects the memory-configuration register (per_cs bit 0). That register is 8 bits wide and uses the upper lane.
- R3: Word addresses 0x8200–0x8262 select video (per_cs bit 1), and 0x8604–0x860C select DMA (per_cs bit 2). Both regions pass bus_wdata and the read data unchanged as 16-bit words.
- R4: Word addresses 0xFA00–0xFA3E select the multi-function block (per_cs bit 3). A write places bus_wdata[15:8] on per_wdata[7:0] with per_wdata[15:8] = 0. A read returns {mfp_rdata, 8'hFF}.
- R5: Word addresses 0xFC00–0xFC06 select an ACIA. Address bit 2 set selects MIDI (per_cs bit 5) and bit 2 clear selects keyboard (per_cs bit 4). bus_vpa is 1 together with the acknowledge, and data uses the upper lane.
- R6: A write anywhere in 0x8800–0x88FE asserts no per_cs and produces one strobe cycle with psg_bdir = psg_bc2 = 1. In that cycle psg_bc1 is 1 only if address bit 1 is clear, and psg_dout = bus_wdata[15:8]. After the strobe all three lines return to 0.
- R7: A read in the sound window produces one strobe cycle with psg_bc1 = psg_bc2 = 1 and psg_bdir = 0. The acknowledge then returns {psg_din sampled during the strobe, 8'hFF}.
- R8: A non-sound access is acknowledged in the cycle after the request, with ack_delay = 0. For a sound access, the strobe occupies the cycle after `WAIT_CYCLES` wait cycles (the second cycle after the request by default). The acknowledge follows in the next cycle, with ack_delay = 2·`WAIT_CYCLES` half-cycles.
- R9: A request with bus_ds low is dropped. It causes no acknowledge, no chip-select, no unmapped flag, no bus_vpa and no strobe.
- R10: A word address outside every region is still acknowledged, with bus_unmapped = 1, per_cs = 0, per_rd = per_wr = 0 and bus_rdata = 16'hFFFF. Examples are 0x8002, 0x8264, 0x8602, 0x860E, 0x8900, 0xFA40 and 0xFC08.
- R11: Requests that arrive while a sound sequence is in progress, from its request until its acknowledge, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle access request |
| bus_ds | input | 1 | Data strobe active for this request |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Byte address within the I/O window |
| bus_wdata | input | 16 | Write data from the master |
| bus_ack | output | 1 | Access complete |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| bus_vpa | output | 1 | Synchronous-peripheral cycle indication |
| bus_unmapped | output | 1 | Access hit no region |
| ack_delay | output | DLY_W | Extra delay in half-cycles, valid with bus_ack |
| per_cs | output | 6 | One-hot select: 0 mcfg, 1 video, 2 DMA, 3 mfp, 4 kbd ACIA, 5 MIDI ACIA |
| per_rd | output | 1 | Read strobe to selected peripheral |
| per_wr | output | 1 | Write strobe to selected peripheral |
| per_index | output | 15 | Register index (address >> 1) |
| per_wdata | output | 16 | Write data, byte-routed for 8-bit regions |
| mcfg_rdata | input | 8 | Memory-configuration read byte |
| video_rdata | input | 16 | Video read word |
| dma_rdata | input | 16 | DMA read word |
| mfp_rdata | input | 8 | Multi-function block read byte |
| kbd_rdata | input | 8 | Keyboard ACIA read byte |
| midi_rdata | input | 8 | MIDI ACIA read byte |
| psg_bdir | output | 1 | Sound generator bus direction line |
| psg_bc2 | output | 1 | Sound generator bus control 2 |
| psg_bc1 | output | 1 | Sound generator bus control 1 |
| psg_dout | output | 8 | Byte to the sound generator |
| psg_din | input | 8 | Byte from the sound generator |

## Verification
The effect of a bad internal state depends on where it sits:
- A wrong region register shows up in the very next cycle, as a wrong per_cs bit, a missing bus_vpa, or a bus_rdata lane that does not match the region width.
- A stuck or mis-counting sound sequencer shows up as a strobe with the wrong control-line pattern, as a strobe lasting more than one cycle, or as an acknowledge arriving in a cycle other than the one set by `WAIT_CYCLES`.
- A busy flag that clears too early lets a request made during the sequence produce a second, stray acknowledge one cycle later.

Each acknowledge carries the cycle at which it was expected. This means timing slips are caught at the first transfer they affect.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int BYTE_W = DATA_W / 2;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int CS_W   = 6;

  localparam logic [ADDR_W-1:0] MCFG_ADDR = 16'h8000;
  localparam logic [ADDR_W-1:0] VID_LO    = 16'h8200;
  localparam logic [ADDR_W-1:0] VID_HI    = 16'h8262;
  localparam logic [ADDR_W-1:0] DMA_LO    = 16'h8604;
  localparam logic [ADDR_W-1:0] DMA_HI    = 16'h860C;
  localparam logic [ADDR_W-1:0] SND_LO    = 16'h8800;
  localparam logic [ADDR_W-1:0] SND_HI    = 16'h88FE;
  localparam logic [ADDR_W-1:0] MFP_LO    = 16'hFA00;
  localparam logic [ADDR_W-1:0] MFP_HI    = 16'hFA3E;
  localparam logic [ADDR_W-1:0] SER_LO    = 16'hFC00;
  localparam logic [ADDR_W-1:0] SER_HI    = 16'hFC06;

  localparam int CS_MCFG = 0;
  localparam int CS_VID  = 1;
  localparam int CS_DMA  = 2;
  localparam int CS_MFP  = 3;
  localparam int CS_KBD  = 4;
  localparam int CS_MIDI = 5;

  typedef enum logic [2:0] {
    RG_NONE, RG_MCFG, RG_VID, RG_DMA, RG_SND, RG_MFP, RG_KBD, RG_MIDI
  } region_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_WAIT, SQ_STRB, SQ_DONE
  } snd_state_e;

  function automatic logic [CS_W-1:0] cs_of(region_e r);
    logic [CS_W-1:0] v;
    v = '0;
    case (r)
      RG_MCFG: v[CS_MCFG] = 1'b1;
      RG_VID:  v[CS_VID]  = 1'b1;
      RG_DMA:  v[CS_DMA]  = 1'b1;
      RG_MFP:  v[CS_MFP]  = 1'b1;
      RG_KBD:  v[CS_KBD]  = 1'b1;
      RG_MIDI: v[CS_MIDI] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/io_region_decode.sv
module io_region_decode
  import io_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              wide
);

  logic [ADDR_W-1:0] waddr;

  always_comb begin
    waddr = {addr[ADDR_W-1:1], 1'b0};
    if (waddr == MCFG_ADDR)
      region = RG_MCFG;
    else if (waddr >= VID_LO && waddr <= VID_HI)
      region = RG_VID;
    else if (waddr >= DMA_LO && waddr <= DMA_HI)
      region = RG_DMA;
    else if (waddr >= SND_LO && waddr <= SND_HI)
      region = RG_SND;
    else if (waddr >= MFP_LO && waddr <= MFP_HI)
      region = RG_MFP;
    else if (waddr >= SER_LO && waddr <= SER_HI)
      region = waddr[2] ? RG_MIDI : RG_KBD;
    else
      region = RG_NONE;
    wide = (region == RG_VID) || (region == RG_DMA);
  end

endmodule

// File: rtl/io_snd_sequencer.sv
module io_snd_sequencer
  import io_dec_pkg::*;
#(
  parameter int WAIT_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic              start_latch,
  input  logic [BYTE_W-1:0] start_byte,
  input  logic [BYTE_W-1:0] din,
  output logic              bdir,
  output logic              bc2,
  output logic              bc1,
  output logic [BYTE_W-1:0] dout,
  output logic [BYTE_W-1:0] cap,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYCLES - 1);

  snd_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rd_q, latch_q;
  logic [BYTE_W-1:0] byte_q, cap_q;
  logic              load_en, cap_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    case (state_q)
      SQ_IDLE: if (start) begin
        load_en = 1'b1;
        cnt_d   = CNT_LOAD;
        state_d = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (cnt_q == '0) state_d = SQ_STRB;
        else             cnt_d   = cnt_q - 1'b1;
      end
      SQ_STRB: begin
        cap_en  = rd_q;
        state_d = SQ_DONE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      latch_q <= 1'b0;
      byte_q  <= '0;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (load_en) begin
        rd_q    <= start_rd;
        latch_q <= start_latch;
        byte_q  <= start_byte;
      end
      if (cap_en) cap_q <= din;
    end
  end

  assign bc2  = (state_q == SQ_STRB);
  assign bdir = bc2 && !rd_q;
  assign bc1  = bc2 && (rd_q || latch_q);
  assign dout = byte_q;
  assign cap  = cap_q;
  assign busy = (state_q != SQ_IDLE);
  assign done = (state_q == SQ_DONE);

endmodule

// File: rtl/io_read_router.sv
module io_read_router
  import io_dec_pkg::*;
(
  input  logic              valid,
  input  region_e           region,
  input  logic              snd_done,
  input  logic [BYTE_W-1:0] snd_cap,
  input  logic [BYTE_W-1:0] mcfg_rdata,
  input  logic [DATA_W-1:0] video_rdata,
  input  logic [DATA_W-1:0] dma_rdata,
  input  logic [BYTE_W-1:0] mfp_rdata,
  input  logic [BYTE_W-1:0] kbd_rdata,
  input  logic [BYTE_W-1:0] midi_rdata,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [BYTE_W-1:0] FILL = '1;

  always_comb begin
    if (snd_done)
      rdata = {snd_cap, FILL};
    else if (!valid)
      rdata = '1;
    else begin
      case (region)
        RG_MCFG: rdata = {mcfg_rdata, FILL};
        RG_VID:  rdata = video_rdata;
        RG_DMA:  rdata = dma_rdata;
        RG_MFP:  rdata = {mfp_rdata, FILL};
        RG_KBD:  rdata = {kbd_rdata, FILL};
        RG_MIDI: rdata = {midi_rdata, FILL};
        default: rdata = '1;
      endcase
    end
  end

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import io_dec_pkg::*;
#(
  parameter int WAIT_CYCLES = 1,
  parameter int DLY_W       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_ds,
  input  logic                bus_rd,
  input  logic [15:0]         bus_addr,
  input  logic [15:0]         bus_wdata,
  output logic                bus_ack,
  output logic [15:0]         bus_rdata,
  output logic                bus_vpa,
  output logic                bus_unmapped,
  output logic [DLY_W-1:0]    ack_delay,
  output logic [5:0]          per_cs,
  output logic                per_rd,
  output logic                per_wr,
  output logic [14:0]         per_index,
  output logic [15:0]         per_wdata,
  input  logic [7:0]          mcfg_rdata,
  input  logic [15:0]         video_rdata,
  input  logic [15:0]         dma_rdata,
  input  logic [7:0]          mfp_rdata,
  input  logic [7:0]          kbd_rdata,
  input  logic [7:0]          midi_rdata,
  output logic                psg_bdir,
  output logic                psg_bc2,
  output logic                psg_bc1,
  output logic [7:0]          psg_dout,
  input  logic [7:0]          psg_din
);

  localparam logic [DLY_W-1:0] SND_DELAY = DLY_W'(2 * WAIT_CYCLES);

  region_e           rgn, rgn_q;
  logic              wide;
  logic              accept, hit, snd_start, snd_busy, snd_done;
  logic [BYTE_W-1:0] snd_cap;
  logic              acc_d, acc_q;
  logic [CS_W-1:0]   cs_d, cs_q;
  logic              rd_d, rd_q, wr_d, wr_q, vpa_d, vpa_q, unm_d, unm_q;
  logic [DATA_W-1:0] wd_d, wd_q;
  logic [IDX_W-1:0]  idx_q;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = bus_addr[0];

  io_region_decode u_decode (
    .addr   (bus_addr),
    .region (rgn),
    .wide   (wide)
  );

  always_comb begin
    accept    = bus_req && bus_ds && !snd_busy;
    hit       = (rgn != RG_NONE) && (rgn != RG_SND);
    snd_start = accept && (rgn == RG_SND);
    acc_d     = accept && (rgn != RG_SND);
    cs_d      = accept ? cs_of(rgn) : '0;
    rd_d      = accept && hit && bus_rd;
    wr_d      = accept && hit && !bus_rd;
    vpa_d     = accept && ((rgn == RG_KBD) || (rgn == RG_MIDI));
    unm_d     = accept && (rgn == RG_NONE);
    wd_d      = wide ? bus_wdata : {{BYTE_W{1'b0}}, bus_wdata[DATA_W-1:BYTE_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      cs_q  <= '0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      vpa_q <= 1'b0;
      unm_q <= 1'b0;
      rgn_q <= RG_NONE;
      idx_q <= '0;
      wd_q  <= '0;
    end else begin
      acc_q <= acc_d;
      cs_q  <= cs_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      vpa_q <= vpa_d;
      unm_q <= unm_d;
      if (accept) begin
        rgn_q <= rgn;
        idx_q <= bus_addr[ADDR_W-1:1];
        wd_q  <= wd_d;
      end
    end
  end

  io_snd_sequencer #(.WAIT_CYCLES(WAIT_CYCLES)) u_snd (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (snd_start),
    .start_rd    (bus_rd),
    .start_latch (!bus_addr[1]),
    .start_byte  (bus_wdata[DATA_W-1:BYTE_W]),
    .din         (psg_din),
    .bdir        (psg_bdir),
    .bc2         (psg_bc2),
    .bc1         (psg_bc1),
    .dout        (psg_dout),
    .cap         (snd_cap),
    .busy        (snd_busy),
    .done        (snd_done)
  );

  io_read_router u_router (
    .valid       (acc_q),
    .region      (rgn_q),
    .snd_done    (snd_done),
    .snd_cap     (snd_cap),
    .mcfg_rdata  (mcfg_rdata),
    .video_rdata (video_rdata),
    .dma_rdata   (dma_rdata),
    .mfp_rdata   (mfp_rdata),
    .kbd_rdata   (kbd_rdata),
    .midi_rdata  (midi_rdata),
    .rdata       (bus_rdata)
  );

  assign bus_ack      = acc_q || snd_done;
  assign ack_delay    = snd_done ? SND_DELAY : '0;
  assign bus_vpa      = vpa_q;
  assign bus_unmapped = unm_q;
  assign per_cs       = cs_q;
  assign per_rd       = rd_q;
  assign per_wr       = wr_q;
  assign per_index    = idx_q;
  assign per_wdata    = wd_q;

endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk #(
  parameter int WAIT_CYCLES = 1,
  parameter int DLY_W       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_ds,
  input logic             bus_ack,
  input logic [15:0]      bus_rdata,
  input logic             bus_vpa,
  input logic             bus_unmapped,
  input logic [DLY_W-1:0] ack_delay,
  input logic [5:0]       per_cs,
  input logic             psg_bdir,
  input logic             psg_bc2,
  input logic             psg_bc1
);

  localparam logic [DLY_W-1:0] EXP_DLY = DLY_W'(2 * WAIT_CYCLES);

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_cs));

  // R3
  cs_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_cs != 6'd0) |-> bus_ack);

  // R6
  bc2_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psg_bdir || psg_bc1) |-> psg_bc2);

  // R7
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psg_bc2 && !psg_bdir) |-> psg_bc1);

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psg_bc2 |=> !psg_bc2 && !psg_bdir && !psg_bc1);

  // R8
  strobe_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psg_bc2 |=> bus_ack && (ack_delay == EXP_DLY) && (per_cs == 6'd0));

  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_unmapped |-> bus_ack && (per_cs == 6'd0) && (bus_rdata == 16'hFFFF));

  // R5
  vpa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vpa |-> bus_ack && (per_cs[4] || per_cs[5]));

  // R9
  no_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ds) |=> (per_cs == 6'd0) && !bus_unmapped && !bus_vpa);

endmodule

bind io_window_decoder io_window_decoder_chk #(
  .WAIT_CYCLES (WAIT_CYCLES),
  .DLY_W       (DLY_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_ds       (bus_ds),
  .bus_ack      (bus_ack),
  .bus_rdata    (bus_rdata),
  .bus_vpa      (bus_vpa),
  .bus_unmapped (bus_unmapped),
  .ack_delay    (ack_delay),
  .per_cs       (per_cs),
  .psg_bdir     (psg_bdir),
  .psg_bc2      (psg_bc2),
  .psg_bc1      (psg_bc1)
);

// File: tb/io_window_decoder_tb.sv
module io_window_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WAITC      = 1;
  localparam int DLYW       = 4;

  localparam logic [7:0]  V_MCFG = 8'h5A;
  localparam logic [15:0] V_VID  = 16'hA5C3;
  localparam logic [15:0] V_DMA  = 16'h1234;
  localparam logic [7:0]  V_MFP  = 8'h3C;
  localparam logic [7:0]  V_KBD  = 8'h81;
  localparam logic [7:0]  V_MIDI = 8'h42;
  localparam logic [7:0]  V_SND  = 8'h9E;

  logic clk, rst_n;
  logic bus_req, bus_ds, bus_rd;
  logic [15:0] bus_addr, bus_wdata;
  logic bus_ack, bus_vpa, bus_unmapped;
  logic [15:0] bus_rdata;
  logic [DLYW-1:0] ack_delay;
  logic [5:0] per_cs;
  logic per_rd, per_wr;
  logic [14:0] per_index;
  logic [15:0] per_wdata;
  logic psg_bdir, psg_bc2, psg_bc1;
  logic [7:0] psg_dout;

  io_window_decoder #(.WAIT_CYCLES(WAITC), .DLY_W(DLYW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ds(bus_ds),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_vpa(bus_vpa),
    .bus_unmapped(bus_unmapped), .ack_delay(ack_delay), .per_cs(per_cs),
    .per_rd(per_rd), .per_wr(per_wr), .per_index(per_index),
    .per_wdata(per_wdata), .mcfg_rdata(V_MCFG), .video_rdata(V_VID),
    .dma_rdata(V_DMA), .mfp_rdata(V_MFP), .kbd_rdata(V_KBD),
    .midi_rdata(V_MIDI), .psg_bdir(psg_bdir), .psg_bc2(psg_bc2),
    .psg_bc1(psg_bc1), .psg_dout(psg_dout), .psg_din(V_SND)
  );

  typedef struct {
    string       tag;
    int          cyc;
    bit          snd;
    bit          rd;
    logic [5:0]  cs;
    logic [14:0] idx;
    logic [15:0] wdata;
    logic [15:0] rdata;
    bit          vpa;
    bit          unm;
  } ack_item_t;

  typedef struct {
    string      tag;
    int         cyc;
    bit         bdir;
    bit         bc1;
    logic [7:0] dout;
  } strb_item_t;

  ack_item_t  ack_q[$];
  strb_item_t strb_q[$];
  int n_chk, n_err, cyc;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected behaviour per requirement, computed from word address.
  task automatic access(input string tag, input logic [15:0] a, input bit rd,
                        input logic [15:0] wd, input bit ds);
    ack_item_t it;
    strb_item_t st;
    logic [15:0] w;
    w = {a[15:1], 1'b0};
    it.tag = tag; it.snd = 0; it.rd = rd; it.cs = 6'd0; it.idx = a[15:1];
    it.vpa = 0; it.unm = 0; it.cyc = cyc + 1;
    it.wdata = {8'h00, wd[15:8]}; it.rdata = 16'hFFFF;
    if (w == 16'h8000) begin it.cs = 6'b000001; it.rdata = {V_MCFG, 8'hFF}; end
    else if (w >= 16'h8200 && w <= 16'h8262) begin
      it.cs = 6'b000010; it.wdata = wd; it.rdata = V_VID; end
    else if (w >= 16'h8604 && w <= 16'h860C) begin
      it.cs = 6'b000100; it.wdata = wd; it.rdata = V_DMA; end
    else if (w >= 16'h8800 && w <= 16'h88FE) begin
      it.snd = 1; it.cyc = cyc + 2 + WAITC; it.rdata = {V_SND, 8'hFF};
      st.tag = tag; st.cyc = cyc + 1 + WAITC; st.bdir = !rd;
      st.bc1 = rd || !w[1]; st.dout = wd[15:8];
      if (ds) strb_q.push_back(st);
    end
    else if (w >= 16'hFA00 && w <= 16'hFA3E) begin
      it.cs = 6'b001000; it.rdata = {V_MFP, 8'hFF}; end
    else if (w >= 16'hFC00 && w <= 16'hFC06) begin
      it.vpa = 1;
      if (w[2]) begin it.cs = 6'b100000; it.rdata = {V_MIDI, 8'hFF}; end
      else      begin it.cs = 6'b010000; it.rdata = {V_KBD, 8'hFF}; end
    end
    else it.unm = 1;
    if (ds) ack_q.push_back(it);
    bus_req = 1; bus_ds = ds; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_req = 0; bus_ds = 0;
    repeat (5) @(negedge clk);
  endtask

  // Monitor: compares each acknowledge and each strobe with the queues.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (bus_ack) begin
        if (ack_q.size() == 0) chk(0, "R9/R11", "unexpected ack", 1, 0);
        else begin
          ack_item_t e;
          e = ack_q.pop_front();
          chk(cyc == e.cyc, e.tag, "R8 ack cycle", cyc, e.cyc);
          chk(per_cs == e.cs, e.tag, "cs", per_cs, e.cs);
          chk(bus_vpa == e.vpa, e.tag, "vpa", bus_vpa, e.vpa);
          chk(bus_unmapped == e.unm, e.tag, "unmapped", bus_unmapped, e.unm);
          chk(ack_delay == (e.snd ? DLYW'(2*WAITC) : '0), e.tag, "R8 delay",
              ack_delay, e.snd ? 2*WAITC : 0);
          if (e.rd || e.unm) chk(bus_rdata == e.rdata, e.tag, "rdata", bus_rdata, e.rdata);
          if (e.cs != 0) begin
            chk(per_index == e.idx, e.tag, "index", per_index, e.idx);
            chk(per_rd == e.rd && per_wr == !e.rd, e.tag, "rd/wr",
                {per_rd, per_wr}, {e.rd, !e.rd});
            if (!e.rd) chk(per_wdata == e.wdata, e.tag, "wdata", per_wdata, e.wdata);
          end else
            chk(!per_rd && !per_wr, e.tag, "R10 no rd/wr", {per_rd, per_wr}, 0);
        end
      end
      if (psg_bc2 || psg_bc1 || psg_bdir) begin
        if (strb_q.size() == 0) chk(0, "R9/R11", "unexpected strobe", 1, 0);
        else begin
          strb_item_t s;
          s = strb_q.pop_front();
          chk(cyc == s.cyc, s.tag, "R8 strobe cycle", cyc, s.cyc);
          chk({psg_bdir, psg_bc2, psg_bc1} == {s.bdir, 1'b1, s.bc1}, s.tag,
              "lines", {psg_bdir, psg_bc2, psg_bc1}, {s.bdir, 1'b1, s.bc1});
          if (s.bdir) chk(psg_dout == s.dout, s.tag, "R6 dout", psg_dout, s.dout);
        end
      end
    end
  end

  initial begin
    int wd_cnt;
    wd_cnt = 0;
    while (wd_cnt < 20000) begin @(posedge clk); wd_cnt++; end
    chk(0, "WDOG", "watchdog expired", wd_cnt, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 0; bus_req = 0; bus_ds = 0; bus_rd = 0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!bus_ack && per_cs == 0 && !psg_bc2 && !psg_bc1 && !psg_bdir && !bus_vpa
        && !bus_unmapped && !per_rd && !per_wr, "R1", "reset outputs",
        {bus_ack, per_cs, psg_bc2}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_ack && per_cs == 0 && !psg_bc2, "R1", "after release",
        {bus_ack, per_cs, psg_bc2}, 0);

    access("R2", 16'h8000, 0, 16'hAB00, 1);
    access("R2", 16'h8001, 1, 16'h0000, 1);
    access("R3", 16'h8200, 0, 16'hBEEF, 1);
    access("R3", 16'h8263, 1, 16'h0000, 1);
    access("R3", 16'h8604, 0, 16'hC0DE, 1);
    access("R3", 16'h860C, 1, 16'h0000, 1);
    access("R4", 16'hFA3E, 0, 16'h7711, 1);
    access("R4", 16'hFA00, 1, 16'h0000, 1);
    access("R5", 16'hFC02, 1, 16'h0000, 1);
    access("R5", 16'hFC04, 0, 16'h6600, 1);
    access("R5", 16'hFC06, 1, 16'h0000, 1);
    access("R6", 16'h8800, 0, 16'h0700, 1);
    access("R6", 16'h88FE, 0, 16'h3F00, 1);
    access("R6", 16'h8842, 0, 16'h1100, 1);
    access("R6", 16'h8885, 0, 16'h2200, 1);
    access("R7", 16'h8802, 1, 16'h0000, 1);
    access("R7", 16'h88A0, 1, 16'h0000, 1);
    access("R10", 16'h8002, 1, 16'h0000, 1);
    access("R10", 16'h8264, 1, 16'h0000, 1);
    access("R10", 16'h8602, 1, 16'h0000, 1);
    access("R10", 16'h860E, 1, 16'h0000, 1);
    access("R10", 16'h8900, 1, 16'h0000, 1);
    access("R10", 16'hFA40, 1, 16'h0000, 1);
    access("R10", 16'hFC08, 0, 16'h1234, 1);
    // R9: data strobe inactive, no ack or strobe expected (monitor flags any)
    access("R9", 16'h8200, 0, 16'h5555, 0);
    access("R9", 16'h8800, 0, 16'h5500, 0);
    access("R9", 16'h1234, 1, 16'h0000, 0);
    chk(per_cs == 0 && !bus_ack, "R9", "idle after dropped", {per_cs, bus_ack}, 0);

    // R11: a video request during the sound wait cycle is ignored
    begin
      ack_item_t it;
      strb_item_t st;
      it.tag = "R11"; it.snd = 1; it.rd = 0; it.cs = 0; it.idx = 0;
      it.wdata = 0; it.rdata = 16'hFFFF; it.vpa = 0; it.unm = 0;
      it.cyc = cyc + 2 + WAITC;
      st.tag = "R11"; st.cyc = cyc + 1 + WAITC; st.bdir = 1; st.bc1 = 1;
      st.dout = 8'h0A;
      ack_q.push_back(it); strb_q.push_back(st);
      bus_req = 1; bus_ds = 1; bus_rd = 0; bus_addr = 16'h8810; bus_wdata = 16'h0A00;
      @(negedge clk);
      bus_addr = 16'h8200; bus_wdata = 16'h9999;
      @(negedge clk);
      bus_req = 0; bus_ds = 0;
      repeat (5) @(negedge clk);
      chk(per_cs == 0, "R11", "no select after busy", per_cs, 0);
    end

    chk(ack_q.size() == 0, "R8", "acks outstanding", ack_q.size(), 0);
    chk(strb_q.size() == 0, "R6", "strobes outstanding", strb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule